// File: doc/BRIEF.md
# Serial EEPROM Array Command Engine

This block is the memory side of a two-wire bus slave that fronts a 256-byte storage array. A bus front end outside the block detects start and stop conditions and samples the data line on each rising clock edge. It delivers those events as single-cycle pulses. The engine frames them into bytes and decides when to pull the data line low, either to acknowledge or to send a zero data bit. It drives the line through one output.

On the write side, the engine matches the device byte and loads the address pointer from the address byte. It collects data bytes into a 16-entry page buffer whose index wraps inside the page. A correctly placed stop commits the buffer to the array and starts a self-timed write cycle, WR_CYCLES clocks long. While that cycle runs, no device byte is acknowledged, so a master can poll for completion. On the read side, the engine supports current-address reads, random reads through a dummy write and a repeated start, and sequential reads that wrap across the whole array. It also blocks writes to a protected upper address range. It tracks whether the pointer is still usable after accesses to other targets that share the device type.

Top module: `eectl_top`

## Requirements
- R1: A device byte is acknowledged only if its upper nibble is 1010, its bits 3..1 are 000 and no write cycle is running. Bit 0 selects read (1) or write (0). Any other device byte gets no acknowledge, and the engine ignores the bus until the next start.
- R2: After a write-type device byte, the next byte is the address. When it is acknowledged it loads the pointer. A stop right after it ends the transfer with the pointer set, so a later current-address read begins at that address.
- R3: In a write, each data byte is acknowledged and stored at the pointer's low four bits. Those bits then increment and wrap within the 16-byte page while the upper four bits stay fixed. For example, 12 bytes from address 0x2B land at 0x2B..0x2F and then 0x20..0x26, and the pointer ends at 0x27.
- R4: When more than 16 data bytes arrive, later bytes replace the earlier bytes at the same page offset.
- R5: A stop that comes inside a data byte, or after its eighth bit but before its acknowledge slot, cancels the whole write. The array stays unchanged and no write cycle starts.
- R6: A stop after one or more complete, acknowledged data bytes commits them to the array and starts a write cycle of WR_CYCLES clocks. During that cycle, device bytes get no acknowledge. Afterwards they are acknowledged again.
- R7: A read sends the byte at the pointer, MSB first. The line is pulled low for each 0 bit. The pointer then increments across all 256 bytes and wraps from 0xFF to 0x00. Another byte follows whenever the master pulls the acknowledge slot low. A high acknowledge slot ends the read.
- R8: A random read is a dummy write (device byte, then address byte) followed by a repeated start and a read-type device byte. It returns data from the given address on.
- R9: After reset, and after any device byte with type 1010 and a target other than 000 (which this block does not acknowledge), the pointer is invalid. A current-address read then returns 0xFF and leaves the pointer invalid until an address byte is accepted.
- R10: While prot_en is high, an address byte greater than or equal to prot_from is not acknowledged. The pointer is left unchanged and no write can follow.
- R11: Out of reset the block does not pull the data line low and is not in a write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_start | input | 1 | One-cycle pulse: start or repeated start detected |
| bus_stop | input | 1 | One-cycle pulse: stop detected |
| bus_bit_vld | input | 1 | One-cycle pulse: a bus clock rising edge sampled a bit |
| bus_bit | input | 1 | Data line value sampled with bus_bit_vld |
| prot_en | input | 1 | Enables protection of the upper address range |
| prot_from | input | 8 | Lowest protected address |
| sda_pull | output | 1 | High when the slave pulls the data line low |

## Verification
The assertions check these rules on every cycle:
- no acknowledge is given to a device byte while a write cycle runs;
- the page bits of the pointer stay fixed across data bytes;
- a stop placed inside a byte never starts a write cycle;
- a read with an invalid pointer always carries the 0xFF filler;
- no acknowledge is given to a protected address;
- the write timer never exceeds its bound.

Only the bench scenarios can show what data actually ends up in the array and what comes back out. That covers in-page wrap order, overwrite beyond 16 bytes, sequential wrap at 0xFF, and pointer invalidation by foreign targets. The bench shows these by comparing every acknowledge slot and every read byte against a behavioural model of the array and pointer.

// File: rtl/eectl_pkg.sv
package eectl_pkg;
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_DEV   = 3'd1,
        PH_ADDR  = 3'd2,
        PH_WDATA = 3'd3,
        PH_RDATA = 3'd4,
        PH_SKIP  = 3'd5
    } phase_e;

    localparam logic [3:0] DEV_TYPE  = 4'b1010;
    localparam logic [2:0] ARRAY_TGT = 3'b000;
    localparam int         BYTE_W    = 8;
endpackage

// File: rtl/eectl_wtimer.sv
module eectl_wtimer #(
    parameter int CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic busy
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (go)
            cnt_d = CNT_W'(CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(CYCLES));
endmodule

// File: rtl/eectl_store.sv
module eectl_store #(
    parameter int PAGE_W = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 commit,
    input  logic [eectl_pkg::BYTE_W-PAGE_W-1:0]  cpage,
    input  logic [(1<<PAGE_W)-1:0][7:0]          cdata,
    input  logic [(1<<PAGE_W)-1:0]               cmask,
    input  logic [eectl_pkg::BYTE_W-1:0]         raddr,
    output logic [7:0]                           rdata
);
    localparam int AW    = eectl_pkg::BYTE_W;
    localparam int DEPTH = 1 << AW;
    localparam int PAGE  = 1 << PAGE_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (commit) begin
            for (int i = 0; i < PAGE; i++)
                if (cmask[i]) mem[{cpage, PAGE_W'(i)}] <= cdata[i];
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/eectl_top.sv
module eectl_top #(
    parameter int         PAGE_W    = 4,
    parameter int         WR_CYCLES = 500000,
    parameter logic [7:0] DUMMY     = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_start,
    input  logic       bus_stop,
    input  logic       bus_bit_vld,
    input  logic       bus_bit,
    input  logic       prot_en,
    input  logic [7:0] prot_from,
    output logic       sda_pull
);
    import eectl_pkg::*;

    localparam int AW   = BYTE_W;
    localparam int PAGE = 1 << PAGE_W;

    typedef struct packed {
        phase_e                  phase;
        logic [3:0]              bitcnt;
        logic [7:0]              sh;
        logic                    ack;
        logic [AW-1:0]           ptr;
        logic                    pvalid;
        logic [7:0]              obyte;
        logic [PAGE-1:0][7:0]    pbuf;
        logic [PAGE-1:0]         pmask;
        logic                    has_data;
    } st_t;

    st_t        q, n;
    logic       commit, busy;
    logic [7:0] rdata, sh_in;

    eectl_store #(.PAGE_W(PAGE_W)) u_store (
        .clk(clk), .rst_n(rst_n), .commit(commit),
        .cpage(q.ptr[AW-1:PAGE_W]), .cdata(q.pbuf), .cmask(q.pmask),
        .raddr(q.ptr), .rdata(rdata)
    );

    eectl_wtimer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .go(commit), .busy(busy)
    );

    always_comb begin
        n      = q;
        commit = 1'b0;
        sh_in  = {q.sh[6:0], bus_bit};
        if (bus_start) begin
            n.phase    = PH_DEV;
            n.bitcnt   = '0;
            n.ack      = 1'b0;
            n.has_data = 1'b0;
            n.pmask    = '0;
        end else if (bus_stop) begin
            commit     = (q.phase == PH_WDATA) && (q.bitcnt == 4'd0) && q.has_data;
            n.phase    = PH_IDLE;
            n.bitcnt   = '0;
            n.ack      = 1'b0;
            n.has_data = 1'b0;
            n.pmask    = '0;
        end else if (bus_bit_vld && q.phase != PH_IDLE && q.phase != PH_SKIP) begin
            if (q.bitcnt != 4'd8) begin
                n.bitcnt = q.bitcnt + 4'd1;
                if (q.phase != PH_RDATA) n.sh = sh_in;
                if (q.bitcnt == 4'd7) begin
                    case (q.phase)
                        PH_DEV:   n.ack = (sh_in[7:4] == DEV_TYPE) &&
                                          (sh_in[3:1] == ARRAY_TGT) && !busy;
                        PH_ADDR:  n.ack = !(prot_en && sh_in >= prot_from);
                        PH_WDATA: n.ack = 1'b1;
                        default:  n.ack = 1'b0;
                    endcase
                end
            end else begin
                n.bitcnt = '0;
                n.ack    = 1'b0;
                case (q.phase)
                    PH_DEV: begin
                        if (q.sh[7:4] == DEV_TYPE && q.sh[3:1] != ARRAY_TGT)
                            n.pvalid = 1'b0;
                        if (!q.ack) begin
                            n.phase = PH_SKIP;
                        end else if (q.sh[0]) begin
                            n.phase = PH_RDATA;
                            n.obyte = q.pvalid ? rdata : DUMMY;
                            if (q.pvalid) n.ptr = q.ptr + 1'b1;
                        end else begin
                            n.phase = PH_ADDR;
                        end
                    end
                    PH_ADDR: begin
                        if (q.ack) begin
                            n.phase  = PH_WDATA;
                            n.ptr    = q.sh;
                            n.pvalid = 1'b1;
                        end else begin
                            n.phase  = PH_SKIP;
                        end
                    end
                    PH_WDATA: begin
                        n.pbuf[q.ptr[PAGE_W-1:0]]  = q.sh;
                        n.pmask[q.ptr[PAGE_W-1:0]] = 1'b1;
                        n.ptr[PAGE_W-1:0]          = q.ptr[PAGE_W-1:0] + 1'b1;
                        n.has_data                 = 1'b1;
                    end
                    PH_RDATA: begin
                        if (!bus_bit) begin
                            n.obyte = q.pvalid ? rdata : DUMMY;
                            if (q.pvalid) n.ptr = q.ptr + 1'b1;
                        end else begin
                            n.phase = PH_SKIP;
                        end
                    end
                    default: n.phase = PH_SKIP;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_comb begin
        sda_pull = 1'b0;
        if (q.bitcnt == 4'd8 && q.ack &&
            (q.phase == PH_DEV || q.phase == PH_ADDR || q.phase == PH_WDATA))
            sda_pull = 1'b1;
        else if (q.phase == PH_RDATA && q.bitcnt < 4'd8)
            sda_pull = !q.obyte[~q.bitcnt[2:0]];
    end

    assert_busy_nack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_DEV && q.bitcnt == 4'd8 && busy) |-> !sda_pull);

    assert_page_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_bit_vld && !bus_start && !bus_stop && q.phase == PH_WDATA && q.bitcnt == 4'd8)
        |=> (q.ptr[AW-1:PAGE_W] == $past(q.ptr[AW-1:PAGE_W])));

    assert_midbyte_cancel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stop && !bus_start && q.phase == PH_WDATA && q.bitcnt != 4'd0) |=> !busy);

    assert_dummy_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_RDATA && !q.pvalid) |-> (q.obyte == DUMMY));

    assert_lock_nack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_ADDR && q.bitcnt == 4'd8 && prot_en && q.sh >= prot_from)
        |-> !sda_pull);
endmodule

// File: tb/eectl_top_test.sv
module eectl_top_test;
    localparam int WRC = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_start = 1'b0, bus_stop = 1'b0, bus_bit_vld = 1'b0, bus_bit = 1'b1;
    logic       prot_en = 1'b0;
    logic [7:0] prot_from = 8'hC0;
    logic       sda_pull;

    int tests = 0, fails = 0, cyc = 0;
    bit done = 0;

    // behavioural model
    byte unsigned mem [256];
    int  ptr = 0;
    bit  pvalid = 0, busy = 0;
    byte unsigned pend_d [$];
    int  pend_a [$];

    eectl_top #(.PAGE_W(4), .WR_CYCLES(WRC), .DUMMY(8'hFF)) uut (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .bus_bit_vld(bus_bit_vld), .bus_bit(bus_bit), .prot_en(prot_en),
        .prot_from(prot_from), .sda_pull(sda_pull)
    );

    always #5 clk = ~clk;

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            tests++; fails++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cyc);
            finish_run();
        end
    end

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_bit(input bit v);
        @(negedge clk); bus_bit_vld = 1'b1; bus_bit = v;
        @(negedge clk); bus_bit_vld = 1'b0; bus_bit = 1'b1;
    endtask

    task automatic do_start();
        @(negedge clk); bus_start = 1'b1;
        @(negedge clk); bus_start = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); bus_stop = 1'b1;
        @(negedge clk); bus_stop = 1'b0;
    endtask

    // send 8 bits, check acknowledge slot
    task automatic tx_byte(input byte unsigned b, input bit exp_ack, input string req);
        for (int i = 7; i >= 0; i--) pulse_bit(b[i]);
        check(req, sda_pull, exp_ack);
        pulse_bit(1'b1);
    endtask

    function automatic bit m_dev_ack(input byte unsigned b);
        if (b[7:4] == 4'hA && b[3:1] != 3'd0) pvalid = 0;
        return (b[7:4] == 4'hA) && (b[3:1] == 3'd0) && !busy;
    endfunction

    function automatic byte unsigned m_next();
        byte unsigned v;
        if (!pvalid) return 8'hFF;
        v = mem[ptr];
        ptr = (ptr + 1) % 256;
        return v;
    endfunction

    task automatic rx_byte(input bit mack, input string req);
        byte unsigned got = 0;
        byte unsigned exp = m_next();
        for (int i = 7; i >= 0; i--) begin
            got[i] = !sda_pull;
            pulse_bit(1'b1);
        end
        check(req, got, exp);
        pulse_bit(!mack);
    endtask

    task automatic dev(input byte unsigned b, input string req);
        bit e = m_dev_ack(b);
        tx_byte(b, e, req);
    endtask

    task automatic addr_byte(input byte unsigned a, input string req);
        bit e = !(prot_en && a >= prot_from);
        if (e) begin ptr = a; pvalid = 1; end
        tx_byte(a, e, req);
    endtask

    task automatic data_byte(input byte unsigned d, input string req);
        tx_byte(d, 1'b1, req);
        pend_a.push_back(ptr);
        pend_d.push_back(d);
        ptr = (ptr & 8'hF0) | ((ptr + 1) & 8'h0F);
    endtask

    task automatic stop_commit();
        if (pend_a.size() > 0) begin
            foreach (pend_a[k]) mem[pend_a[k]] = pend_d[k];
            busy = 1;
        end
        pend_a.delete(); pend_d.delete();
        do_stop();
    endtask

    task automatic wait_cycle();
        repeat (WRC + 5) @(negedge clk);
        busy = 0;
    endtask

    task automatic page_write(input byte unsigned a, input int cnt, input byte unsigned base,
                              input string req);
        do_start(); dev(8'hA0, req); addr_byte(a, req);
        for (int i = 0; i < cnt; i++) data_byte(byte'(base + i), req);
        stop_commit(); wait_cycle();
    endtask

    task automatic rand_read(input byte unsigned a, input int cnt, input string req);
        do_start(); dev(8'hA0, req); addr_byte(a, req);
        do_start(); dev(8'hA1, req);
        for (int i = 0; i < cnt; i++) rx_byte(i != cnt - 1, req);
        do_stop();
    endtask

    task automatic cur_read(input int cnt, input string req);
        do_start(); dev(8'hA1, req);
        for (int i = 0; i < cnt; i++) rx_byte(i != cnt - 1, req);
        do_stop();
    endtask

    initial begin
        foreach (mem[i]) mem[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset idle line", sda_pull, 0);

        // R9: pointer invalid out of reset -> filler byte
        cur_read(2, "R9 read before init");

        // R1: wrong device type, no ack
        do_start(); dev(8'h31, "R1 foreign type nack"); do_stop();
        do_start(); dev(8'hB0, "R1 wrong type nack"); do_stop();

        // R3 page write with in-page wrap, R6 polling
        do_start(); dev(8'hA0, "R1 array write ack"); addr_byte(8'h2B, "R2 address ack");
        for (int i = 0; i < 12; i++) data_byte(byte'(8'h40 + i), "R3 data ack");
        stop_commit();
        do_start(); dev(8'hA0, "R6 nack while busy"); do_stop();
        do_start(); dev(8'hA1, "R6 nack read while busy"); do_stop();
        wait_cycle();
        check("R3 pointer after wrap", ptr, 8'h27);
        cur_read(3, "R3 current read from 0x27");
        rand_read(8'h20, 16, "R8 random read whole page");

        // R4 overwrite beyond 16
        page_write(8'h50, 18, 8'h80, "R4 long page write");
        rand_read(8'h50, 3, "R4 overwrite check");

        // R5 stop inside a data byte
        do_start(); dev(8'hA0, "R5 setup"); addr_byte(8'h60, "R5 setup");
        tx_byte(8'h11, 1'b1, "R5 first byte ack");
        pulse_bit(1); pulse_bit(0); pulse_bit(1);
        pend_a.delete(); pend_d.delete();
        do_stop();
        do_start(); dev(8'hA0, "R5 not busy after cancel"); do_stop();
        ptr = 8'h60; // address byte above set pointer; model keeps it
        rand_read(8'h60, 2, "R5 array unchanged");

        // R5 stop after eighth bit, before ack slot
        do_start(); dev(8'hA0, "R5 setup"); addr_byte(8'h70, "R5 setup");
        for (int i = 7; i >= 0; i--) pulse_bit(1'b1);
        do_stop();
        do_start(); dev(8'hA0, "R5 not busy after late stop"); do_stop();
        rand_read(8'h70, 1, "R5 array unchanged at slot");

        // R2 set pointer only, R7 sequential wrap
        page_write(8'hFE, 2, 8'hC7, "R7 seed top");
        page_write(8'h00, 1, 8'h5A, "R7 seed bottom");
        do_start(); dev(8'hA0, "R2 set pointer"); addr_byte(8'hFE, "R2 set pointer"); do_stop();
        cur_read(4, "R7 wrap FF to 00");

        // R9 foreign target invalidates pointer
        do_start(); dev(8'hAE, "R9 other target nack"); do_stop();
        cur_read(1, "R9 filler after other target");
        rand_read(8'h20, 1, "R9 random read restores");
        cur_read(1, "R9 current read valid again");

        // R10 protected range
        prot_en = 1'b1;
        do_start(); dev(8'hA0, "R10 setup"); addr_byte(8'hC4, "R10 locked nack"); do_stop();
        cur_read(1, "R10 pointer unchanged");
        page_write(8'hBF, 1, 8'h33, "R10 below lock writable");
        rand_read(8'hBF, 1, "R10 below lock data");
        prot_en = 1'b0;

        finish_run();
    end
endmodule